// File: doc/BRIEF.md
# Accelerator Launch and Argument Register File

This block sits between a host-facing AXI4-Lite slave port and a compute engine. The host uses it to load the engine's arguments, launch a run, watch for completion and take interrupts. Every argument has a 64-bit slot in the map. Scalar arguments may be 32 or 64 bits wide. Pointer arguments are always 64-bit offsets into a partition of global memory. Every argument value is driven continuously to the engine on one flat bus. A 64-bit value is loaded with two separate word writes, one to the low word and one to the high word.

The control word follows three clearing rules:
- The start request is cleared by the block itself when the engine is launched.
- The completion flag is cleared when the host reads the control word.
- Interrupt status bits are cleared only when the host writes a one to them.

A single interrupt line combines a global enable, per-event enables and the status bits. Three small state machines do the work:
- The write channel machine has the states WR_IDLE, WR_HAVE_ADDR, WR_HAVE_DATA, WR_COMMIT and WR_RESP.
  - WR_IDLE goes to WR_HAVE_ADDR or WR_HAVE_DATA when only one of the two channels presents a beat.
  - WR_IDLE goes straight to WR_COMMIT when both present a beat together.
  - Either half state goes to WR_COMMIT when the missing beat arrives.
  - WR_COMMIT always goes to WR_RESP.
  - WR_RESP returns to WR_IDLE when the host accepts the response.
- The read channel machine goes from RD_IDLE to RD_RESP when an address is accepted, and back to RD_IDLE when the read data is taken.
- The run machine goes from CT_IDLE to CT_RUN when a pending start is launched, and from CT_RUN back to CT_IDLE when the engine reports completion.

Top module: `accel_ctrl_regs`

## Requirements
- R1: After reset, the control word reads 0x0000_0004 (only idle set). All other registers read zero, `start_o` is low and `irq_o` is low.
- R2: The map uses these 32-bit words:
  - 0x00 control: bit0 start, bit1 done, bit2 idle, bit7 auto-restart.
  - 0x04 global interrupt enable, in bit0.
  - 0x08 interrupt enable: bit0 done event, bit1 ready (launch) event.
  - 0x0C interrupt status, with the same bit layout as 0x08.
  - From 0x10 on, argument i has its low word at 0x10+8i and its high word at 0x14+8i.
  - Default argument order: scalar0 (32-bit), scalar1 (64-bit), pointer0, pointer1.
  - Reads of unmapped or unaligned addresses return zero, and writes to them are ignored.
- R3: Write address and write data may arrive in either order or together. A write response is given only after both have been accepted. A write takes effect once, and a pending response or read data is held until the host accepts it.
- R4: Each write honours its byte strobes: only the bytes whose strobe is set change.
- R5: For a scalar of 32 bits or fewer, the upper word is reserved. Writes to it are ignored, it reads zero, and bits 63:32 of that argument on `args_o` stay zero.
- R6: A 64-bit argument is loaded by two separate word writes. Its full value appears on `args_o[64i+63:64i]`.
- R7: Writing a 1 to start sets a start request.
  - The block launches the engine with a one-cycle `start_o` pulse and clears the request itself.
  - A request made while a run is in progress stays pending and reads back as 1.
  - A pending request launches as soon as that run completes.
  - Writing 0 to start has no effect.
- R8: A `done_i` strobe during a run sets done and returns the block to idle. Idle is low while running. Done clears when the host reads the control word. A `done_i` strobe while idle is ignored.
- R9: An interrupt status bit is set by its event only when its enable bit is set. It stays set until the host writes a 1 to that bit position, and other bits are unaffected.
- R10: `irq_o` is high exactly when the global enable is set and at least one status bit is set whose enable bit is also set.
- R11: When auto-restart is set, each completion immediately starts a new run with another `start_o` pulse. Clearing auto-restart stops this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| done_i | input | 1 | Completion strobe from the engine |
| start_o | output | 1 | One-cycle launch pulse to the engine |
| irq_o | output | 1 | Interrupt request |
| args_o | output | 64*N_ARGS | Argument values, argument i in bits 64i+63:64i |

## Verification
- **Writes.** A register write takes effect on the second clock edge after the later of the two channel handshakes: one edge to WR_COMMIT, one to update. The response becomes valid at that same edge, so the bench waits for the response before reading anything back.
- **Reads.** Read data is registered on the edge that accepts the address and is valid for the next cycle. The read-clear of done happens on that same edge. The scoreboard pops an expected word whenever it sees a valid beat on the falling edge.
- **Launch and completion.** A start pulse appears one edge after the start request is registered. A completion strobe updates done, idle and status on the edge that samples it. The bench therefore waits two or three cycles before it checks pulse counts, and it reads registers only through the bus.

// File: rtl/accel_regs_pkg.sv
package accel_regs_pkg;

    // word indices within the register map
    localparam int unsigned WORD_CTRL = 0;
    localparam int unsigned WORD_GIE  = 1;
    localparam int unsigned WORD_IER  = 2;
    localparam int unsigned WORD_ISR  = 3;
    localparam int unsigned WORD_ARG0 = 4;

    // control word bit positions
    localparam int unsigned CB_START = 0;
    localparam int unsigned CB_DONE  = 1;
    localparam int unsigned CB_IDLE  = 2;
    localparam int unsigned CB_AUTO  = 7;

    // interrupt event positions
    localparam int unsigned EV_DONE  = 0;
    localparam int unsigned EV_READY = 1;
    localparam int unsigned N_EV     = 2;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [2:0] {
        WR_IDLE,
        WR_HAVE_ADDR,
        WR_HAVE_DATA,
        WR_COMMIT,
        WR_RESP
    } wr_state_t;

    typedef enum logic {
        RD_IDLE,
        RD_RESP
    } rd_state_t;

    typedef enum logic {
        CT_IDLE,
        CT_RUN
    } ct_state_t;

    function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                                input logic [31:0] new_v,
                                                input logic [3:0]  strb);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            r[8*b +: 8] = strb[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/axil_wr_fsm.sv
module axil_wr_fsm
    import accel_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr_i,
    input  logic              awvalid_i,
    output logic              awready_o,
    input  logic [31:0]       wdata_i,
    input  logic [3:0]        wstrb_i,
    input  logic              wvalid_i,
    output logic              wready_o,
    output logic              bvalid_o,
    input  logic              bready_i,
    output logic              commit_o,
    output logic [ADDR_W-1:0] cap_addr_o,
    output logic [31:0]       cap_data_o,
    output logic [3:0]        cap_strb_o
);

    wr_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: begin
                if (awvalid_i && wvalid_i) state_d = WR_COMMIT;
                else if (awvalid_i)        state_d = WR_HAVE_ADDR;
                else if (wvalid_i)         state_d = WR_HAVE_DATA;
            end
            WR_HAVE_ADDR: if (wvalid_i)  state_d = WR_COMMIT;
            WR_HAVE_DATA: if (awvalid_i) state_d = WR_COMMIT;
            WR_COMMIT:                   state_d = WR_RESP;
            WR_RESP:      if (bready_i)  state_d = WR_IDLE;
            default:                     state_d = WR_IDLE;
        endcase
    end

    always_comb begin
        awready_o = (state_q == WR_IDLE) || (state_q == WR_HAVE_DATA);
        wready_o  = (state_q == WR_IDLE) || (state_q == WR_HAVE_ADDR);
        commit_o  = (state_q == WR_COMMIT);
        bvalid_o  = (state_q == WR_RESP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr_o <= '0;
            cap_data_o <= '0;
            cap_strb_o <= '0;
        end else begin
            if (awvalid_i && awready_o) cap_addr_o <= awaddr_i;
            if (wvalid_i && wready_o) begin
                cap_data_o <= wdata_i;
                cap_strb_o <= wstrb_i;
            end
        end
    end

    // R3
    bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid_o && !bready_i |=> bvalid_o);

    // R3
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

endmodule

// File: rtl/axil_rd_fsm.sv
module axil_rd_fsm
    import accel_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arvalid_i,
    output logic        arready_o,
    output logic        rvalid_o,
    input  logic        rready_i,
    output logic        take_o,
    input  logic [31:0] word_i,
    output logic [31:0] rdata_o
);

    rd_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (arvalid_i) state_d = RD_RESP;
            RD_RESP: if (rready_i)  state_d = RD_IDLE;
            default:                state_d = RD_IDLE;
        endcase
    end

    always_comb begin
        arready_o = (state_q == RD_IDLE);
        rvalid_o  = (state_q == RD_RESP);
        take_o    = arvalid_i && arready_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_o <= '0;
        else if (take_o) rdata_o <= word_i;
    end

    // R3
    rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o && !rready_i |=> rvalid_o && $stable(rdata_o));

endmodule

// File: rtl/run_ctrl.sv
module run_ctrl
    import accel_regs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_ctrl_i,
    input  logic            wr_gie_i,
    input  logic            wr_ier_i,
    input  logic            wr_isr_i,
    input  logic [7:0]      wbyte_i,
    input  logic            rd_ctrl_i,
    input  logic            done_i,
    output logic            start_o,
    output logic            irq_o,
    output logic [7:0]      ctrl_word_o,
    output logic            gie_o,
    output logic [N_EV-1:0] ier_o,
    output logic [N_EV-1:0] isr_o
);

    ct_state_t state_q, state_d;

    logic            start_req_q;
    logic            auto_q;
    logic            done_q;
    logic            launch;
    logic            finish;
    logic [N_EV-1:0] ev;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CT_IDLE: if (start_req_q) state_d = CT_RUN;
            CT_RUN:  if (done_i)      state_d = CT_IDLE;
            default:                  state_d = CT_IDLE;
        endcase
    end

    always_comb begin
        launch          = (state_q == CT_IDLE) && start_req_q;
        finish          = (state_q == CT_RUN) && done_i;
        ev              = '0;
        ev[EV_DONE]     = finish;
        ev[EV_READY]    = launch;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o     <= 1'b0;
            start_req_q <= 1'b0;
            auto_q      <= 1'b0;
            done_q      <= 1'b0;
            gie_o       <= 1'b0;
            ier_o       <= '0;
            isr_o       <= '0;
        end else begin
            start_o <= launch;

            if (launch)                start_req_q <= 1'b0;
            else if (finish && auto_q) start_req_q <= 1'b1;
            if (wr_ctrl_i && wbyte_i[CB_START]) start_req_q <= 1'b1;

            if (wr_ctrl_i) auto_q <= wbyte_i[CB_AUTO];

            if (rd_ctrl_i) done_q <= 1'b0;
            if (finish)    done_q <= 1'b1;

            if (wr_gie_i) gie_o <= wbyte_i[0];
            if (wr_ier_i) ier_o <= wbyte_i[N_EV-1:0];

            isr_o <= (isr_o & ~(wr_isr_i ? wbyte_i[N_EV-1:0] : '0)) | (ev & ier_o);
        end
    end

    always_comb begin
        ctrl_word_o           = '0;
        ctrl_word_o[CB_START] = start_req_q;
        ctrl_word_o[CB_DONE]  = done_q;
        ctrl_word_o[CB_IDLE]  = (state_q == CT_IDLE);
        ctrl_word_o[CB_AUTO]  = auto_q;
        irq_o                 = gie_o && |(isr_o & ier_o);
    end

    // R7
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R7
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !ctrl_word_o[CB_IDLE]);

    // R8
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_q) |-> $past(rd_ctrl_i));

    // R8
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(done_i));

    // R9
    isr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(isr_o[EV_DONE]) |-> $past(wr_isr_i && wbyte_i[EV_DONE]));

endmodule

// File: rtl/arg_bank.sv
module arg_bank
    import accel_regs_pkg::*;
#(
    parameter int unsigned         N_ARGS = 4,
    parameter int unsigned         WIDX_W = 6,
    parameter logic [N_ARGS-1:0]   WIDE   = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [WIDX_W-1:0]     wr_word_i,
    input  logic [31:0]           wdata_i,
    input  logic [3:0]            wstrb_i,
    output logic [64*N_ARGS-1:0]  args_o
);

    for (genvar i = 0; i < N_ARGS; i++) begin : g_arg
        localparam logic [WIDX_W-1:0] LO_IDX = WIDX_W'(WORD_ARG0 + 2*i);
        localparam logic [WIDX_W-1:0] HI_IDX = WIDX_W'(WORD_ARG0 + 2*i + 1);

        logic [31:0] lo_q;

        always_ff @(posedge clk) begin
            if (!rst_n)                             lo_q <= '0;
            else if (wr_en_i && wr_word_i == LO_IDX) lo_q <= merge_bytes(lo_q, wdata_i, wstrb_i);
        end
        assign args_o[64*i +: 32] = lo_q;

        if (WIDE[i]) begin : g_wide
            logic [31:0] hi_q;
            always_ff @(posedge clk) begin
                if (!rst_n)                             hi_q <= '0;
                else if (wr_en_i && wr_word_i == HI_IDX) hi_q <= merge_bytes(hi_q, wdata_i, wstrb_i);
            end
            assign args_o[64*i+32 +: 32] = hi_q;
        end else begin : g_narrow
            assign args_o[64*i+32 +: 32] = '0;
        end
    end

endmodule

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs
    import accel_regs_pkg::*;
#(
    parameter int unsigned            ADDR_W      = 8,
    parameter int unsigned            N_SCALAR    = 2,
    parameter logic [N_SCALAR-1:0]    SCALAR_WIDE = 2'b10,
    parameter int unsigned            N_PTR       = 2,
    localparam int unsigned           N_ARGS      = N_SCALAR + N_PTR
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     s_awaddr,
    input  logic                  s_awvalid,
    output logic                  s_awready,
    input  logic [31:0]           s_wdata,
    input  logic [3:0]            s_wstrb,
    input  logic                  s_wvalid,
    output logic                  s_wready,
    output logic [1:0]            s_bresp,
    output logic                  s_bvalid,
    input  logic                  s_bready,
    input  logic [ADDR_W-1:0]     s_araddr,
    input  logic                  s_arvalid,
    output logic                  s_arready,
    output logic [31:0]           s_rdata,
    output logic [1:0]            s_rresp,
    output logic                  s_rvalid,
    input  logic                  s_rready,
    input  logic                  done_i,
    output logic                  start_o,
    output logic                  irq_o,
    output logic [64*N_ARGS-1:0]  args_o
);

    localparam int unsigned        WIDX_W   = ADDR_W - 2;
    localparam logic [N_ARGS-1:0]  ARG_WIDE = {{N_PTR{1'b1}}, SCALAR_WIDE};

    logic              commit;
    logic [ADDR_W-1:0] cap_addr;
    logic [31:0]       cap_data;
    logic [3:0]        cap_strb;
    logic              wr_ok;
    logic [WIDX_W-1:0] wr_word;
    logic              wr_b0;

    logic              rd_take;
    logic              rd_ok;
    logic [WIDX_W-1:0] rd_word;
    logic [31:0]       rd_mux;

    logic [7:0]        ctrl_word;
    logic              gie;
    logic [N_EV-1:0]   ier;
    logic [N_EV-1:0]   isr;

    assign s_bresp = RESP_OKAY;
    assign s_rresp = RESP_OKAY;

    axil_wr_fsm #(.ADDR_W(ADDR_W)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .awaddr_i   (s_awaddr),
        .awvalid_i  (s_awvalid),
        .awready_o  (s_awready),
        .wdata_i    (s_wdata),
        .wstrb_i    (s_wstrb),
        .wvalid_i   (s_wvalid),
        .wready_o   (s_wready),
        .bvalid_o   (s_bvalid),
        .bready_i   (s_bready),
        .commit_o   (commit),
        .cap_addr_o (cap_addr),
        .cap_data_o (cap_data),
        .cap_strb_o (cap_strb)
    );

    axil_rd_fsm u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .arvalid_i (s_arvalid),
        .arready_o (s_arready),
        .rvalid_o  (s_rvalid),
        .rready_i  (s_rready),
        .take_o    (rd_take),
        .word_i    (rd_mux),
        .rdata_o   (s_rdata)
    );

    always_comb begin
        wr_ok   = commit && (cap_addr[1:0] == 2'b00);
        wr_word = cap_addr[ADDR_W-1:2];
        wr_b0   = wr_ok && cap_strb[0];
        rd_ok   = (s_araddr[1:0] == 2'b00);
        rd_word = s_araddr[ADDR_W-1:2];
    end

    run_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl_i   (wr_b0 && wr_word == WIDX_W'(WORD_CTRL)),
        .wr_gie_i    (wr_b0 && wr_word == WIDX_W'(WORD_GIE)),
        .wr_ier_i    (wr_b0 && wr_word == WIDX_W'(WORD_IER)),
        .wr_isr_i    (wr_b0 && wr_word == WIDX_W'(WORD_ISR)),
        .wbyte_i     (cap_data[7:0]),
        .rd_ctrl_i   (rd_take && rd_ok && rd_word == WIDX_W'(WORD_CTRL)),
        .done_i      (done_i),
        .start_o     (start_o),
        .irq_o       (irq_o),
        .ctrl_word_o (ctrl_word),
        .gie_o       (gie),
        .ier_o       (ier),
        .isr_o       (isr)
    );

    arg_bank #(
        .N_ARGS (N_ARGS),
        .WIDX_W (WIDX_W),
        .WIDE   (ARG_WIDE)
    ) u_args (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_ok),
        .wr_word_i (wr_word),
        .wdata_i   (cap_data),
        .wstrb_i   (cap_strb),
        .args_o    (args_o)
    );

    always_comb begin
        rd_mux = '0;
        if (rd_ok) begin
            if (rd_word == WIDX_W'(WORD_CTRL)) rd_mux = {24'd0, ctrl_word};
            if (rd_word == WIDX_W'(WORD_GIE))  rd_mux = {31'd0, gie};
            if (rd_word == WIDX_W'(WORD_IER))  rd_mux = {{(32-N_EV){1'b0}}, ier};
            if (rd_word == WIDX_W'(WORD_ISR))  rd_mux = {{(32-N_EV){1'b0}}, isr};
            for (int i = 0; i < int'(N_ARGS); i++) begin
                if (rd_word == WIDX_W'(WORD_ARG0 + 2*i))     rd_mux = args_o[64*i +: 32];
                if (rd_word == WIDX_W'(WORD_ARG0 + 2*i + 1)) rd_mux = args_o[64*i+32 +: 32];
            end
        end
    end

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (gie && (isr != '0)));

endmodule

// File: tb/accel_ctrl_regs_tb.sv
module accel_ctrl_regs_tb;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned N_ARGS = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [ADDR_W-1:0]    s_awaddr = '0;
    logic                 s_awvalid = 1'b0;
    logic                 s_awready;
    logic [31:0]          s_wdata = '0;
    logic [3:0]           s_wstrb = '0;
    logic                 s_wvalid = 1'b0;
    logic                 s_wready;
    logic [1:0]           s_bresp;
    logic                 s_bvalid;
    logic                 s_bready = 1'b1;
    logic [ADDR_W-1:0]    s_araddr = '0;
    logic                 s_arvalid = 1'b0;
    logic                 s_arready;
    logic [31:0]          s_rdata;
    logic [1:0]           s_rresp;
    logic                 s_rvalid;
    logic                 s_rready = 1'b1;
    logic                 done_i = 1'b0;
    logic                 start_o;
    logic                 irq_o;
    logic [64*N_ARGS-1:0] args_o;

    int checks = 0;
    int errors = 0;
    int pulses = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    accel_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .done_i(done_i), .start_o(start_o), .irq_o(irq_o), .args_o(args_o)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read words as beats appear
    always @(negedge clk) begin
        if (rst_n && s_rvalid && s_rready) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R3 unexpected read beat: actual=%h expected=none", s_rdata);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (s_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", t, s_rdata, e);
                end
            end
        end
        if (rst_n && start_o) pulses++;
    end

    // order: 0 together, 1 address first, 2 data first
    task automatic axi_write(input logic [7:0] a, input logic [31:0] d,
                             input logic [3:0] s, input int order);
        bit aw_done = 0;
        bit w_done  = 0;
        @(negedge clk);
        s_awaddr = a;
        s_wdata  = d;
        s_wstrb  = s;
        if (order != 2) s_awvalid = 1'b1;
        if (order != 1) s_wvalid  = 1'b1;
        while (!(aw_done && w_done)) begin
            bit hs_aw;
            bit hs_w;
            hs_aw = s_awvalid && s_awready;
            hs_w  = s_wvalid && s_wready;
            @(negedge clk);
            if (hs_aw) begin s_awvalid = 1'b0; aw_done = 1; end
            if (hs_w)  begin s_wvalid  = 1'b0; w_done  = 1; end
            if (aw_done != w_done && !s_awvalid && !s_wvalid) begin
                repeat (3) @(negedge clk);
                chk({63'd0, s_bvalid}, 64'd0, "R3 no response before both halves");
                if (!aw_done) s_awvalid = 1'b1;
                if (!w_done)  s_wvalid  = 1'b1;
            end
        end
        while (!s_bvalid) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic axi_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        s_araddr  = a;
        s_arvalid = 1'b1;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk({63'd0, start_o}, 64'd0, "R1 start low");
        chk({63'd0, irq_o}, 64'd0, "R1 irq low");
        axi_read(8'h00, 32'h4, "R1 ctrl after reset");
        axi_read(8'h04, 32'h0, "R1 gie after reset");
        axi_read(8'h08, 32'h0, "R1 ier after reset");
        axi_read(8'h0C, 32'h0, "R1 isr after reset");
        axi_read(8'h10, 32'h0, "R1 arg after reset");

        // arguments, R3 channel orders, R4 strobes, R5 reserved, R6 wide
        axi_write(8'h10, 32'h1122_3344, 4'hF, 0);
        axi_write(8'h14, 32'hFFFF_FFFF, 4'hF, 0);
        axi_write(8'h18, 32'hAABB_CCDD, 4'hF, 1);
        axi_write(8'h1C, 32'h0102_0304, 4'hF, 2);
        axi_write(8'h20, 32'hCAFE_F00D, 4'hF, 2);
        axi_write(8'h24, 32'h0000_0001, 4'hF, 1);
        axi_write(8'h28, 32'hFFFF_FFFF, 4'hF, 0);
        axi_write(8'h28, 32'h1234_5678, 4'b0101, 0);
        axi_write(8'h12, 32'hFFFF_FFFF, 4'hF, 0);
        axi_read(8'h10, 32'h1122_3344, "R2 scalar0 low, unaligned write ignored");
        axi_read(8'h14, 32'h0, "R5 reserved upper word reads zero");
        axi_read(8'h18, 32'hAABB_CCDD, "R3 address-first write");
        axi_read(8'h1C, 32'h0102_0304, "R3 data-first write");
        axi_read(8'h24, 32'h0000_0001, "R6 pointer high word");
        axi_read(8'h28, 32'hFF34_FF78, "R4 byte strobes");
        axi_read(8'h30, 32'h0, "R2 unmapped reads zero");
        axi_read(8'h11, 32'h0, "R2 unaligned reads zero");
        chk(args_o[63:0], 64'h0000_0000_1122_3344, "R5 narrow scalar on args_o");
        chk(args_o[127:64], 64'h0102_0304_AABB_CCDD, "R6 wide scalar on args_o");
        chk(args_o[191:128], 64'h0000_0001_CAFE_F00D, "R6 pointer0 on args_o");
        chk(args_o[255:192], 64'h0000_0000_FF34_FF78, "R6 pointer1 on args_o");

        // enables and first launch
        axi_write(8'h04, 32'h1, 4'hF, 0);
        axi_write(8'h08, 32'h3, 4'hF, 0);
        axi_read(8'h04, 32'h1, "R2 gie readback");
        axi_read(8'h08, 32'h3, "R2 ier readback");
        axi_write(8'h00, 32'h1, 4'hF, 0);
        repeat (2) @(negedge clk);
        chk(64'(pulses), 64'd1, "R7 one start pulse");
        axi_read(8'h00, 32'h0, "R7 start self-cleared, idle low while running");
        axi_read(8'h0C, 32'h2, "R9 ready event latched");
        chk({63'd0, irq_o}, 64'd1, "R10 irq from ready event");
        axi_write(8'h0C, 32'h2, 4'hF, 0);
        axi_read(8'h0C, 32'h0, "R9 write-one clears status");
        chk({63'd0, irq_o}, 64'd0, "R10 irq low after clear");

        // pending start while running
        axi_write(8'h00, 32'h1, 4'hF, 0);
        axi_read(8'h00, 32'h1, "R7 pending start reads back");
        chk(64'(pulses), 64'd1, "R7 no launch while running");
        pulse_done();
        chk(64'(pulses), 64'd2, "R7 pending start launches after done");
        axi_read(8'h0C, 32'h3, "R9 done and ready events latched");
        axi_read(8'h00, 32'h2, "R8 done set, relaunched so not idle");
        axi_read(8'h00, 32'h0, "R8 done cleared by read");
        axi_write(8'h0C, 32'h1, 4'hF, 0);
        axi_read(8'h0C, 32'h2, "R9 only written bit clears");
        axi_write(8'h0C, 32'h2, 4'hF, 0);

        // completion to idle, interrupt gating
        pulse_done();
        axi_read(8'h00, 32'h6, "R8 done and idle after completion");
        axi_read(8'h00, 32'h4, "R8 done cleared on read");
        chk({63'd0, irq_o}, 64'd1, "R10 irq from done event");
        axi_write(8'h04, 32'h0, 4'hF, 0);
        chk({63'd0, irq_o}, 64'd0, "R10 global enable off masks irq");
        axi_write(8'h04, 32'h1, 4'hF, 0);
        chk({63'd0, irq_o}, 64'd1, "R10 global enable back on");
        axi_write(8'h08, 32'h0, 4'hF, 0);
        chk({63'd0, irq_o}, 64'd0, "R10 per-event enable off masks irq");
        axi_read(8'h0C, 32'h1, "R9 status held while disabled");
        axi_write(8'h08, 32'h3, 4'hF, 0);
        axi_write(8'h0C, 32'h1, 4'hF, 0);

        // done while idle ignored
        pulse_done();
        axi_read(8'h00, 32'h4, "R8 done strobe ignored while idle");
        axi_read(8'h0C, 32'h0, "R8 no event while idle");

        // auto restart
        axi_write(8'h00, 32'h81, 4'hF, 0);
        repeat (2) @(negedge clk);
        chk(64'(pulses), 64'd3, "R11 launch with auto-restart");
        axi_read(8'h00, 32'h80, "R11 auto bit reads back while running");
        pulse_done();
        chk(64'(pulses), 64'd4, "R11 automatic relaunch on done");
        axi_read(8'h00, 32'h82, "R11 done set and running again");
        axi_write(8'h00, 32'h0, 4'hF, 0);
        pulse_done();
        chk(64'(pulses), 64'd4, "R11 no relaunch after auto cleared");
        axi_read(8'h00, 32'h6, "R11 idle after final done");

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule